// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between a simple request/acknowledge host port and an external asynchronous static RAM of 256K words by 4 bits. It runs single read and single write cycles on the memory. It drives the address bus and the three active-low strobes (chip select, output enable, write enable). It controls a 4-bit data bus that is split into out, in and drive-enable signals, so pad tri-stating stays outside the block.

The controller turns the memory's nanosecond timing rules into clock-cycle counts. Read wait, write-strobe width, bus turnaround and the power-on settling time are each given in picoseconds and rounded up at the configured clock period. A write puts the address and data on the pins one cycle ahead of the write strobe and holds them one cycle after it. The memory therefore sees stable data at the rising edge that ends the select/strobe overlap. A read keeps the data bus undriven, lowers select and output enable, and registers the returned word on the last wait cycle. After each access the memory is deselected for the turnaround time. The host sees a one-cycle `ack_o`, with `rdata_o` valid alongside it on reads. Requests that arrive while a cycle is running, or during the power-on wait, are dropped.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, chip select stays high for PWRUP_CYC = ceil(T_PWRUP_PS / CLK_PERIOD_PS) cycles. A request made in that time is dropped: it produces no ack and no memory cycle.
- R2: A write first spends one cycle with chip select low, write strobe high, the data bus driven and the address valid. Only then does the write strobe fall.
- R3: The write strobe stays low for exactly WE_CYC = ceil(T_WE_PS / CLK_PERIOD_PS) cycles, with address and data stable. The word the host supplied is what a later read of that address returns.
- R4: On the cycle the write strobe rises, chip select stays low and the address and data stay driven and unchanged. On the following cycle the data bus is released and chip select is high.
- R5: The controller never drives the data bus while output enable is low. The write strobe is never low while output enable is low, and never low while chip select is high.
- R6: A read holds chip select and output enable low, with the write strobe high, for RD_CYC = ceil(T_RD_PS / CLK_PERIOD_PS) cycles. The word on the data inputs at the last of those cycles is presented on rdata_o.
- R7: ack_o is a single-cycle pulse, one per accepted request. It comes 2 + WE_CYC cycles after the accepting edge for a write, and RD_CYC cycles after it for a read.
- R8: Between two accesses chip select stays high for at least TURN_CYC = ceil(T_TURN_PS / CLK_PERIOD_PS) cycles.
- R9: A request raised while an access is in progress is dropped: it yields no ack and does not change memory.
- R10: During reset, chip select, output enable and the write strobe are high, the data bus is not driven and ack_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request, sampled only when idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 18 | Host word address |
| wdata_i | input | 4 | Host write data |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 4 | Read data, valid with ack_o on reads |
| sram_addr_o | output | 18 | Memory address bus |
| sram_ce_no | output | 1 | Memory chip select, active low |
| sram_oe_no | output | 1 | Memory output enable, active low |
| sram_we_no | output | 1 | Memory write strobe, active low |
| sram_dq_o | output | 4 | Data driven towards the memory |
| sram_dq_i | input | 4 | Data returned from the memory |
| sram_dq_oe_o | output | 1 | Drive enable for the data pads |

## Verification
The assertions assume the host holds `we_i`, `addr_i` and `wdata_i` valid in any cycle where `req_i` is high. They also assume reset is released synchronously to the clock. The bench raises `req_i` for exactly one cycle, with all fields set at the falling edge. It issues its next request only after the acknowledge and the turnaround have elapsed, except for the deliberate mid-access and power-on requests that test dropping. The behavioural memory drives its data only under the read condition, and it returns inverted data until the read wait has elapsed. A capture made too early therefore shows up as a mismatch.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_IDLE,
    ST_WSET,
    ST_WLOW,
    ST_WHOLD,
    ST_READ,
    ST_TURN
  } ctrl_state_e;

  function automatic int unsigned ceil_cyc(int unsigned t_ps, int unsigned clk_ps);
    int unsigned c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int unsigned   W       = 4,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= RST_VAL;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R8: an expired count stays expired until reloaded
  a_r8_timer_parks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o);

endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp #(
  parameter int unsigned AW = 18,
  parameter int unsigned DW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          capture_i,
  input  logic [DW-1:0] dq_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] dq_o,
  output logic [DW-1:0] rdata_o
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_q <= '0;
    else if (capture_i) rdata_q <= dq_i;
  end

  assign addr_o  = addr_q;
  assign dq_o    = wdata_q;
  assign rdata_o = rdata_q;

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW            = 18,
  parameter int unsigned DW            = 4,
  parameter int unsigned CLK_PERIOD_PS = 8000,
  parameter int unsigned T_RD_PS       = 10000,
  parameter int unsigned T_WE_PS       = 7000,
  parameter int unsigned T_TURN_PS     = 3000,
  parameter int unsigned T_PWRUP_PS    = 100_000_000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ack_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] sram_addr_o,
  output logic          sram_ce_no,
  output logic          sram_oe_no,
  output logic          sram_we_no,
  output logic [DW-1:0] sram_dq_o,
  input  logic [DW-1:0] sram_dq_i,
  output logic          sram_dq_oe_o
);

  localparam int unsigned RD_CYC    = ceil_cyc(T_RD_PS, CLK_PERIOD_PS);
  localparam int unsigned WE_CYC    = ceil_cyc(T_WE_PS, CLK_PERIOD_PS);
  localparam int unsigned TURN_CYC  = ceil_cyc(T_TURN_PS, CLK_PERIOD_PS);
  localparam int unsigned PWRUP_CYC = ceil_cyc(T_PWRUP_PS, CLK_PERIOD_PS);
  localparam int unsigned TMR_MAX   = max3(RD_CYC, WE_CYC, TURN_CYC);
  localparam int unsigned TMR_W     = (TMR_MAX < 2) ? 1 : $clog2(TMR_MAX);
  localparam int unsigned PWR_W     = (PWRUP_CYC < 2) ? 1 : $clog2(PWRUP_CYC);

  ctrl_state_e st_q, st_d;
  logic             tmr_load, tmr_zero, pwr_done;
  logic [TMR_W-1:0] tmr_val;
  logic             accept, capture, ack_d, ack_q;

  sram_ctrl_timer #(.W(TMR_W), .RST_VAL('0)) u_phase_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  // free-running settle counter, parks at zero once power-on time is over
  sram_ctrl_timer #(.W(PWR_W), .RST_VAL(PWR_W'(PWRUP_CYC - 1))) u_pwr_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (1'b0),
    .load_val_i ('0),
    .zero_o     (pwr_done)
  );

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    ack_d    = 1'b0;
    unique case (st_q)
      ST_PWRUP: if (pwr_done) st_d = ST_IDLE;
      ST_IDLE: if (req_i) begin
        accept = 1'b1;
        if (we_i) st_d = ST_WSET;
        else begin
          st_d     = ST_READ;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(RD_CYC - 1);
        end
      end
      ST_WSET: begin
        st_d     = ST_WLOW;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(WE_CYC - 1);
      end
      ST_WLOW: if (tmr_zero) st_d = ST_WHOLD;
      ST_WHOLD: begin
        st_d     = ST_TURN;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(TURN_CYC - 1);
        ack_d    = 1'b1;
      end
      ST_READ: if (tmr_zero) begin
        st_d     = ST_TURN;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(TURN_CYC - 1);
        capture  = 1'b1;
        ack_d    = 1'b1;
      end
      ST_TURN: if (tmr_zero) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_PWRUP;
      ack_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ack_q <= ack_d;
    end
  end

  sram_ctrl_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .capture_i (capture),
    .dq_i      (sram_dq_i),
    .addr_o    (sram_addr_o),
    .dq_o      (sram_dq_o),
    .rdata_o   (rdata_o)
  );

  assign sram_ce_no   = !(st_q inside {ST_WSET, ST_WLOW, ST_WHOLD, ST_READ});
  assign sram_we_no   = (st_q != ST_WLOW);
  assign sram_oe_no   = (st_q != ST_READ);
  assign sram_dq_oe_o = (st_q inside {ST_WSET, ST_WLOW, ST_WHOLD});
  assign ack_o        = ack_q;

  a_r1_quiet_until_settled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_done |-> (sram_ce_no && !ack_o));

  a_r2_strobe_after_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sram_we_no) |-> ($past(sram_dq_oe_o) && !$past(sram_ce_no) && $stable(sram_addr_o)));

  a_r3_stable_under_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_we_no && !$past(sram_we_no)) |-> ($stable(sram_addr_o) && $stable(sram_dq_o)));

  a_r4_hold_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> (sram_dq_oe_o && !sram_ce_no && $stable(sram_addr_o) && $stable(sram_dq_o)));

  a_r4_release_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |=> (!sram_dq_oe_o && sram_ce_no));

  a_r5_no_drive_into_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> sram_oe_no);

  a_r5_strobe_needs_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> (!sram_ce_no && !sram_oe_no == 1'b0));

  a_r7_ack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  a_r8_deselect_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (sram_ce_no && !sram_dq_oe_o));

endmodule

// File: tb/sram_async_ctrl_tb_top.sv
module sram_async_ctrl_tb_top;

  localparam int CLK_PS  = 8000;
  localparam int T_RD    = 10000;
  localparam int T_WE    = 7000;
  localparam int T_TURN  = 3000;
  localparam int T_PWR   = 320000;
  localparam int EXP_RD   = (T_RD + CLK_PS - 1) / CLK_PS;
  localparam int EXP_WE   = (T_WE + CLK_PS - 1) / CLK_PS;
  localparam int EXP_TURN = (T_TURN + CLK_PS - 1) / CLK_PS;
  localparam int EXP_PWR  = (T_PWR + CLK_PS - 1) / CLK_PS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [17:0] addr = '0;
  logic [3:0]  wdata = '0;
  logic        ack;
  logic [3:0]  rdata;
  logic [17:0] s_addr;
  logic        s_ce_n, s_oe_n, s_we_n, s_dq_oe;
  logic [3:0]  s_dq_o, s_dq_i;

  int n_tests = 0, n_fail = 0, ops = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sram_async_ctrl #(
    .CLK_PERIOD_PS(CLK_PS), .T_RD_PS(T_RD), .T_WE_PS(T_WE),
    .T_TURN_PS(T_TURN), .T_PWRUP_PS(T_PWR)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata), .sram_addr_o(s_addr),
    .sram_ce_no(s_ce_n), .sram_oe_no(s_oe_n), .sram_we_no(s_we_n),
    .sram_dq_o(s_dq_o), .sram_dq_i(s_dq_i), .sram_dq_oe_o(s_dq_oe)
  );

  logic [3:0] mem_q  [int];
  logic [3:0] shadow [int];

  function automatic logic [3:0] init_val(logic [17:0] a);
    return a[3:0] ^ a[7:4] ^ a[17:14] ^ 4'h9;
  endfunction
  function automatic logic [3:0] mem_get(logic [17:0] a);
    return mem_q.exists(int'(a)) ? mem_q[int'(a)] : init_val(a);
  endfunction
  function automatic logic [3:0] exp_get(logic [17:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : init_val(a);
  endfunction

  task automatic chk(bit ok, string rq, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // behavioural memory: wrong data until the read wait has elapsed
  int         rd_cnt = 0;
  logic [3:0] rd_val = '0;
  wire        mem_drive = !s_ce_n && !s_oe_n && s_we_n;
  assign s_dq_i = mem_drive ? ((rd_cnt >= EXP_RD) ? rd_val : ~rd_val) : 4'h0;

  int cyc = 0, pwr_viol = 0, contention = 0, illegal = 0, turn_viol = 0;
  int ack_total = 0, we_len = 0, ce_hi = 0;
  bit prev_we = 1, prev_ce = 1, prev_dq_oe = 0, hold_chk = 0, seen_acc = 0;
  logic [17:0] prev_addr = '0;
  logic [3:0]  prev_dq = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (cyc <= EXP_PWR && !s_ce_n) pwr_viol++;
      if (ack) ack_total++;
      if (s_dq_oe && mem_drive) contention++;
      if (!s_we_n && (!s_oe_n || s_ce_n)) illegal++;
      rd_cnt <= mem_drive ? rd_cnt + 1 : 0;
      rd_val <= mem_get(s_addr);
      if (prev_we && !s_we_n) begin
        chk(!prev_ce && prev_dq_oe && s_addr == prev_addr && s_dq_o == prev_dq,
            "R2 setup before strobe", {prev_ce, prev_dq_oe}, 2'b01);
        we_len = 1;
      end else if (!prev_we && !s_we_n) begin
        we_len++;
        if (s_addr != prev_addr || s_dq_o != prev_dq) illegal++;
      end
      if (!prev_we && s_we_n) begin
        chk(we_len == EXP_WE, "R3 strobe width", we_len, EXP_WE);
        chk(!s_ce_n && s_dq_oe && s_addr == prev_addr && s_dq_o == prev_dq,
            "R4 hold after strobe", {s_ce_n, s_dq_oe}, 2'b01);
        mem_q[int'(prev_addr)] = prev_dq;
        hold_chk = 1;
      end else if (hold_chk) begin
        chk(s_ce_n && !s_dq_oe, "R4 release", {s_ce_n, s_dq_oe}, 2'b10);
        hold_chk = 0;
      end
      if (prev_ce && !s_ce_n) begin
        if (seen_acc && ce_hi < EXP_TURN) turn_viol++;
        seen_acc = 1;
        ce_hi = 0;
      end
      if (s_ce_n) ce_hi++;
      prev_we = s_we_n; prev_ce = s_ce_n; prev_dq_oe = s_dq_oe;
      prev_addr = s_addr; prev_dq = s_dq_o;
    end
  end

  // called at a falling edge with the controller idle
  task automatic do_op(bit w, logic [17:0] a, logic [3:0] d, bit inject);
    int n = 1, lat;
    int acks_before;
    acks_before = ack_total;
    req = 1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 0;
    lat = w ? 2 + EXP_WE : EXP_RD;
    while (!ack && n < 40) begin
      if (inject && n == 1) begin
        req = 1; we = 1; addr = a ^ 18'h1; wdata = ~d;
      end else req = 0;
      @(negedge clk);
      n++;
    end
    req = 0;
    ops++;
    chk(n == lat + 1, w ? "R7 write ack latency" : "R7 read ack latency", n, lat + 1);
    if (!w) chk(rdata == exp_get(a), "R6 read data", rdata, exp_get(a));
    else shadow[int'(a)] = d;
    @(negedge clk);
    chk(!ack, "R7 ack single cycle", ack, 0);
    if (inject) chk(ack_total == acks_before + 1, "R9 one ack only", ack_total - acks_before, 1);
    repeat (EXP_TURN - 1) @(negedge clk);
  endtask

  initial begin
    logic [17:0] pool [8];
    void'($urandom(32'h1ced));
    repeat (3) @(negedge clk);
    chk(s_ce_n && s_oe_n && s_we_n && !s_dq_oe && !ack, "R10 reset state",
        {s_ce_n, s_oe_n, s_we_n, s_dq_oe, ack}, 5'b11100);
    rst_n = 1;
    repeat (3) @(negedge clk);
    req = 1; we = 1; addr = 18'h00005; wdata = 4'h0;
    @(negedge clk);
    req = 0;
    while (cyc < EXP_PWR + 2) @(negedge clk);
    chk(pwr_viol == 0, "R1 select high while settling", pwr_viol, 0);
    chk(ack_total == 0, "R1 no ack while settling", ack_total, 0);
    do_op(0, 18'h00005, 4'h0, 0);   // R1: dropped write left memory alone

    do_op(1, 18'h00000, 4'hA, 0);
    do_op(1, 18'h3FFFF, 4'h5, 0);
    do_op(0, 18'h00000, 4'h0, 0);   // R3 readback
    do_op(0, 18'h3FFFF, 4'h0, 0);
    do_op(1, 18'h12345, 4'h3, 0);
    do_op(1, 18'h12345, 4'hC, 0);   // back-to-back writes, last wins
    do_op(0, 18'h12345, 4'h0, 0);
    do_op(1, 18'h00100, 4'h7, 1);   // R9 request during a write
    do_op(0, 18'h00101, 4'h0, 0);
    do_op(0, 18'h00200, 4'h0, 1);   // R9 request during a read
    do_op(0, 18'h00201, 4'h0, 0);

    for (int i = 0; i < 8; i++) pool[i] = 18'($urandom);
    for (int i = 0; i < 300; i++) begin
      logic [17:0] a;
      a = pool[$urandom % 8] ^ 18'($urandom % 4);
      do_op(1'($urandom), a, 4'($urandom), 0);
    end

    chk(contention == 0, "R5 bus contention", contention, 0);
    chk(illegal == 0, "R5 strobe legality", illegal, 0);
    chk(turn_viol == 0, "R8 deselect gap", turn_viol, 0);
    chk(ack_total == ops, "R7 one ack per op", ack_total, ops);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule